// File: doc/BRIEF.md
# Timer Interrupt Router with Status

This block takes match events from a set of timer channels and turns them into activity on a bank of interrupt lines. Each channel carries its own configuration word. The word selects whether the channel signals by level or by edge, whether the channel is enabled, which output line it drives, and whether it is diverted to message delivery. A message-diverted channel never touches a line. The block also keeps one status bit per channel. Software reads this status and clears bits by writing 1 to them.

A legacy routing mode fixes the destinations of the two lowest channels. Channel 0 goes to line 0 and channel 1 goes to line 8, whatever their route fields say. In this mode the block also takes line 8 away from the external real-time-clock interrupt input. When legacy mode is off, that RTC level passes straight through to line 8. Event inputs are single-cycle strobes, and status and line state change on the clock edge that samples them.

Top module: `tmr_irq_router`

## Requirements
- R1: A level channel (config bit 1 = 1) sets its status bit on the edge that samples its event. Its line stays high until the bit is cleared.
- R2: An edge channel (config bit 1 = 0) drives its line high for exactly one cycle after the sampling edge. Its status bit stays 0.
- R3: With legacy mode off, a channel drives the line whose number is config bits 13:9. Config bit 2 enables the channel and config bit 14 selects message delivery.
- R4: With legacy mode on, channel 0 drives line 0 and channel 1 drives line 8. All other channels keep their route field.
- R5: If the global enable or a channel's enable is 0, that channel's status bit clears on the next edge, its line goes low, and its events are ignored.
- R6: A status write clears every set bit whose write-data bit is 1. Write-data bits of 0 leave status unchanged. An event in the same cycle wins over the clear.
- R7: With legacy mode off, line 8 carries the RTC input level. With legacy mode on, the RTC input is masked. Leaving legacy mode shows the current RTC level on line 8 again at once.
- R8: A channel with message delivery selected drives no line and holds its status bit at 0.
- R9: A line shared by several channels is the OR of their contributions. Clearing one channel leaves the line high while another channel still holds it.
- R10: After reset, all status bits are 0 and every line is low, except that line 8 follows the RTC input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_event | input | NCH | Per-channel match strobe, one cycle |
| ch_cfg | input | NCH*16 | Per-channel config words, channel c at bits 16c+15:16c |
| glb_en | input | 1 | Global interrupt enable |
| legacy_en | input | 1 | Legacy routing mode |
| rtc_irq | input | 1 | External RTC interrupt level |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NCH | Status write data, 1 clears |
| irq_out | output | NLINE | Interrupt lines |
| sts_rd | output | NCH | Status readback |

## Verification
The bench sweeps every channel over every route in both signalling types. A wrong route decode would light the wrong line. An edge channel that latched status would leave its line stuck high. It writes zeros and unrelated ones to the status register, and it collides a clear with an event in the same cycle. A broken write-1-to-clear would drop a pending level interrupt or lose a new one. Legacy mode is toggled while the RTC input changes, to catch a line 8 that leaks the RTC level or fails to restore it. Two level channels share one line, so a line driven by the last writer instead of the OR would fall early.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int NCH      = 4,
  parameter int NLINE    = 32,
  parameter int RTC_LINE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       ch_event,
  input  logic [NCH*16-1:0]    ch_cfg,
  input  logic                 glb_en,
  input  logic                 legacy_en,
  input  logic                 rtc_irq,
  input  logic                 sts_wr,
  input  logic [NCH-1:0]       sts_wdata,
  output logic [NLINE-1:0]     irq_out,
  output logic [NCH-1:0]       sts_rd
);
  localparam int CFGW  = 16;
  localparam int RW    = $clog2(NLINE);
  localparam int B_LVL = 1;
  localparam int B_EN  = 2;
  localparam int B_RT  = 9;
  localparam int B_MSG = 14;

  logic [NCH-1:0] sts_q, pls_q, lvl, act;
  logic [RW-1:0]  eroute [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CFGW-1:0] cfg;
    assign cfg = ch_cfg[c*CFGW +: CFGW];
    assign lvl[c] = cfg[B_LVL];
    assign act[c] = glb_en & cfg[B_EN] & ~cfg[B_MSG];
    if (c == 0) begin : g_l0
      assign eroute[c] = legacy_en ? RW'(0) : cfg[B_RT +: RW];
    end else if (c == 1) begin : g_l1
      assign eroute[c] = legacy_en ? RW'(RTC_LINE) : cfg[B_RT +: RW];
    end else begin : g_rt
      assign eroute[c] = cfg[B_RT +: RW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts_q[c] <= 1'b0;
        pls_q[c] <= 1'b0;
      end else if (!act[c]) begin
        sts_q[c] <= 1'b0;
        pls_q[c] <= 1'b0;
      end else begin
        pls_q[c] <= ch_event[c] & ~lvl[c];
        if (ch_event[c])                sts_q[c] <= lvl[c];
        else if (sts_wr && sts_wdata[c]) sts_q[c] <= 1'b0;
      end
    end

    // R1: status only rises from a level event
    a_r1_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[c]) |-> $past(ch_event[c] & lvl[c]));
    // R2: an edge event leaves status clear
    a_r2_edge_nosts: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_event[c] && !lvl[c]) |=> !sts_q[c]);
  end

  always_comb begin
    irq_out = '0;
    for (int c = 0; c < NCH; c++)
      if (sts_q[c] | pls_q[c]) irq_out[eroute[c]] = 1'b1;
    if (!legacy_en && rtc_irq) irq_out[RTC_LINE] = 1'b1;
  end

  assign sts_rd = sts_q;

  a_r5_glb_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (sts_q == '0 && pls_q == '0));
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && ch_event == '0) |=> ((sts_q & $past(sts_wdata)) == '0));
  a_r7_rtc_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy_en && rtc_irq) |-> irq_out[RTC_LINE]);
endmodule

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NLINE = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ch_event = '0, sts_wdata = '0, sts_rd;
  logic [NCH*16-1:0] ch_cfg = '0;
  logic glb_en = 0, legacy_en = 0, rtc_irq = 0, sts_wr = 0;
  logic [NLINE-1:0] irq_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_router #(.NCH(NCH), .NLINE(NLINE), .RTC_LINE(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_event(ch_event), .ch_cfg(ch_cfg),
    .glb_en(glb_en), .legacy_en(legacy_en), .rtc_irq(rtc_irq),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .irq_out(irq_out), .sts_rd(sts_rd));

  function automatic logic [15:0] mk(bit lv, bit en, int rt, bit msg);
    logic [15:0] w = '0;
    w[1] = lv; w[2] = en; w[13:9] = rt[4:0]; w[14] = msg;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic fire(logic [NCH-1:0] e);
    ch_event = e; tick(); ch_event = '0;
  endtask

  task automatic clr(logic [NCH-1:0] m);
    sts_wr = 1; sts_wdata = m; tick(); sts_wr = 0; sts_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R10 status", 32'(sts_rd), 0);
    chk("R10 lines", irq_out, 0);
    rst_n = 1; glb_en = 1; tick();

    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NLINE; r++)
        for (int lv = 0; lv < 2; lv++) begin
          ch_cfg = '0;
          ch_cfg[c*16 +: 16] = mk(lv[0], 1, r, 0);
          fire(1 << c);
          chk("R3 route line", irq_out, 32'(1) << r);
          chk(lv ? "R1 status set" : "R2 status zero", 32'(sts_rd), lv ? (32'(1) << c) : 0);
          tick();
          if (lv) begin
            chk("R1 hold", irq_out, 32'(1) << r);
            clr(1 << c);
            chk("R6 clear status", 32'(sts_rd), 0);
            chk("R6 clear line", irq_out, 0);
          end else begin
            chk("R2 single pulse", irq_out, 0);
          end
        end

    // R6: zero and unrelated writes
    ch_cfg = '0; ch_cfg[2*16 +: 16] = mk(1, 1, 5, 0);
    fire(4'b0100);
    clr(4'b0000);
    chk("R6 zero write", 32'(sts_rd), 32'h4);
    clr(4'b1011);
    chk("R6 other bits", irq_out, 32'h20);
    ch_event = 4'b0100; sts_wr = 1; sts_wdata = 4'b0100; tick();
    ch_event = '0; sts_wr = 0; sts_wdata = '0;
    chk("R6 event wins", 32'(sts_rd), 32'h4);

    // R5: global and channel disables
    glb_en = 0; tick();
    chk("R5 glb off status", 32'(sts_rd), 0);
    chk("R5 glb off line", irq_out, 0);
    fire(4'b0100);
    chk("R5 event ignored", 32'(sts_rd), 0);
    glb_en = 1; fire(4'b0100);
    ch_cfg[2*16 +: 16] = mk(1, 0, 5, 0); tick();
    chk("R5 ch off", {irq_out[31:4], sts_rd}, 0);

    // R8: message delivery
    ch_cfg[2*16 +: 16] = mk(1, 1, 5, 1);
    fire(4'b0100);
    chk("R8 no line", irq_out, 0);
    chk("R8 no status", 32'(sts_rd), 0);

    // R9: shared line
    ch_cfg = '0;
    ch_cfg[0 +: 16] = mk(1, 1, 3, 0);
    ch_cfg[16 +: 16] = mk(1, 1, 3, 0);
    fire(4'b0011);
    clr(4'b0001);
    chk("R9 still high", irq_out, 32'h8);
    clr(4'b0010);
    chk("R9 low", irq_out, 0);

    // R4: legacy routes
    ch_cfg = '0;
    ch_cfg[0 +: 16]  = mk(1, 1, 20, 0);
    ch_cfg[16 +: 16] = mk(1, 1, 21, 0);
    ch_cfg[32 +: 16] = mk(1, 1, 22, 0);
    fire(4'b0111);
    chk("R4 normal", irq_out, (32'(1) << 20) | (32'(1) << 21) | (32'(1) << 22));
    legacy_en = 1; #1;
    chk("R4 legacy", irq_out, 32'h1 | 32'h100 | (32'(1) << 22));
    clr(4'b0111);
    legacy_en = 0; tick();

    // R7: RTC pass-through
    rtc_irq = 1; #1;
    chk("R7 pass", irq_out, 32'h100);
    legacy_en = 1; #1;
    chk("R7 masked", irq_out, 0);
    rtc_irq = 0; tick(); rtc_irq = 1; tick();
    chk("R7 masked later", irq_out, 0);
    legacy_en = 0; #1;
    chk("R7 restored", irq_out, 32'h100);
    rtc_irq = 0; #1;
    chk("R7 follows", irq_out, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule